// File: doc/BRIEF.md
# Timer compare output unit

An 8-bit counter drives two compare channels, A and B. Each channel turns its own register value into a pin waveform. A 3-bit waveform mode sets how the counter moves. It can count up freely, clear itself on a channel-A match, wrap at a top value, or bounce up and down between zero and a top value. Each channel has a 2-bit output-mode field. Together with the waveform mode, this field decides whether a compare match sets, clears or toggles that channel's output, or whether the output is released.

The block is meant to sit under a register file that holds the mode fields, the two compare values and the pin direction bits. It also sits under a prescaler that pulses the count enable. Each pin is reported with a flag that says whether the channel has taken the pin over. The pin level is only active when the direction bit also allows driving.

Top module: `tmr_wave_unit`

## Requirements
- R1: While `rst_n` is low, `cnt_q` is 0 and both pins are 0. The output latches of both channels restart at 0.
- R2: The waveform mode `wmode` decodes as follows:
  - 0, 4 and 6: free counting, with wrap from 255 to 0.
  - 2: clear on match.
  - 3 and 7: single-slope PWM. The counter goes from TOP straight back to 0.
  - 1 and 5: dual-slope PWM.
- R3: In modes 0/2/4/6, a field of 01 toggles the output on a match, 10 clears it and 11 sets it. A match is `cnt_q` equal to the compare value while `cnt_en` is high. The pin shows the result from the clock edge that leaves the matching count.
- R4: `ovr_x` is 1 when the channel's field is connected. A field of 00 is never connected, and R8 lists the PWM exceptions. `pin_x` equals the channel's output latch only when both `ovr_x` and `dir_x` are 1. Otherwise `pin_x` is 0.
- R5: In mode 2, the counter goes to 0 on the edge after it equals `cmp_a_in`.
- R6: In single-slope PWM, field 10 clears on a match and sets on the wrap to 0. Field 11 sets on a match and clears on the wrap to 0.
- R7: In PWM modes with the field's upper bit set, a compare value equal to TOP gives no match action. Field 10 is set at the boundary instead and field 11 is cleared at the boundary. The boundary is the wrap to 0 in single-slope mode. In dual-slope mode it is the turn at TOP.
- R8: Field 01 behaves as follows in the PWM modes:
  - Channel B is disconnected.
  - Channel A toggles on a match when `wmode[2]` is 1.
  - Channel A is disconnected when `wmode[2]` is 0.
- R9: In the PWM modes, TOP is 255 when `wmode[2]` is 0. When `wmode[2]` is 1, TOP is the buffered channel-A compare value.
- R10: In the PWM modes, the compare inputs are copied into the working compare values only on an enabled cycle with the counter at TOP. In the other modes the inputs act at once.
- R11: In dual-slope mode, the counter counts 0, 1, …, TOP, TOP−1, …, 0, 1, … and never repeats an end value. A match counts as counting up when the next step goes up. Field 10 clears on an up match and sets on a down match. Field 11 does the reverse.
- R12: While `cnt_en` is low, the counter, the direction and both output latches hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable pulse |
| wmode | input | 3 | Waveform mode |
| cmode_a | input | 2 | Output-mode field, channel A |
| cmode_b | input | 2 | Output-mode field, channel B |
| cmp_a_in | input | 8 | Compare value, channel A |
| cmp_b_in | input | 8 | Compare value, channel B |
| dir_a | input | 1 | Drive allow for pin A |
| dir_b | input | 1 | Drive allow for pin B |
| cnt_q | output | 8 | Counter value |
| pin_a | output | 1 | Pin A level |
| pin_b | output | 1 | Pin B level |
| ovr_a | output | 1 | Channel A owns its pin |
| ovr_b | output | 1 | Channel B owns its pin |

## Verification
Free counting with toggle and set fields tests whether the match is placed on the correct count and the correct edge. A cleared direction bit separates pin ownership from pin drive. The clear-on-match run has a second channel whose compare value falls inside the short period, which checks that the period ends at channel A's value. Single-slope runs with compare values below TOP, equal to TOP and with the reserved field tell the normal duty cycle apart from the boundary-only special case. A compare write in the middle of a period shows whether the buffered copy waits for TOP. Dual-slope runs with both field polarities and a TOP-equal compare value test the direction-dependent actions and the turn handling. An irregular enable pattern shows that nothing moves on idle cycles.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;

  typedef enum logic [1:0] {
    WK_NORMAL = 2'd0,
    WK_CTC    = 2'd1,
    WK_FAST   = 2'd2,
    WK_PHASE  = 2'd3
  } wave_kind_t;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } pin_act_t;

  function automatic wave_kind_t decode_kind(input logic [2:0] wm);
    wave_kind_t k;
    case (wm)
      3'd1, 3'd5: k = WK_PHASE;
      3'd2:       k = WK_CTC;
      3'd3, 3'd7: k = WK_FAST;
      default:    k = WK_NORMAL;
    endcase
    return k;
  endfunction

  function automatic logic is_pwm(input wave_kind_t k);
    return (k == WK_FAST) || (k == WK_PHASE);
  endfunction

  function automatic logic top_from_a(input logic [2:0] wm);
    return wm[2] && is_pwm(decode_kind(wm));
  endfunction

  function automatic logic chan_connected(input wave_kind_t k, input logic [1:0] cm,
                                          input logic is_a, input logic wm2);
    logic c;
    if (cm == 2'b00)                      c = 1'b0;
    else if (is_pwm(k) && cm == 2'b01)    c = is_a && wm2;
    else                                  c = 1'b1;
    return c;
  endfunction

  function automatic pin_act_t match_action(input wave_kind_t k, input logic [1:0] cm,
                                            input logic is_a, input logic wm2,
                                            input logic up);
    pin_act_t a;
    a = ACT_NONE;
    if (cm == 2'b00) begin
      a = ACT_NONE;
    end else if (!is_pwm(k)) begin
      case (cm)
        2'b01:   a = ACT_TGL;
        2'b10:   a = ACT_CLR;
        default: a = ACT_SET;
      endcase
    end else if (cm == 2'b01) begin
      a = (is_a && wm2) ? ACT_TGL : ACT_NONE;
    end else if (k == WK_FAST) begin
      a = (cm == 2'b10) ? ACT_CLR : ACT_SET;
    end else begin
      if (cm == 2'b10) a = up ? ACT_CLR : ACT_SET;
      else             a = up ? ACT_SET : ACT_CLR;
    end
    return a;
  endfunction

  function automatic pin_act_t boundary_action(input logic [1:0] cm);
    pin_act_t a;
    case (cm)
      2'b10:   a = ACT_SET;
      2'b11:   a = ACT_CLR;
      default: a = ACT_NONE;
    endcase
    return a;
  endfunction

  function automatic logic apply_action(input pin_act_t a, input logic cur);
    logic n;
    case (a)
      ACT_SET: n = 1'b1;
      ACT_CLR: n = 1'b0;
      ACT_TGL: n = ~cur;
      default: n = cur;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tmr_wave_counter.sv
module tmr_wave_counter
  import tmr_wave_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  wave_kind_t   kind,
  input  logic [W-1:0] top_val,
  input  logic [W-1:0] ctc_cmp,
  output logic [W-1:0] cnt,
  output logic         up_step,
  output logic         at_top,
  output logic         wrap_evt,
  output logic         turn_evt,
  output logic         load_evt
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic         up_reg;
  logic [W-1:0] cnt_nxt;

  function automatic logic [W-1:0] step_count(input wave_kind_t k, input logic [W-1:0] c,
                                              input logic [W-1:0] t, input logic [W-1:0] m,
                                              input logic up);
    logic [W-1:0] n;
    case (k)
      WK_CTC:   n = (c == m) ? ZERO : c + ONE;
      WK_FAST:  n = (c >= t) ? ZERO : c + ONE;
      WK_PHASE: begin
        if (t == ZERO) n = ZERO;
        else           n = up ? c + ONE : c - ONE;
      end
      default:  n = c + ONE;
    endcase
    return n;
  endfunction

  assign at_top = (cnt >= top_val);

  always_comb begin
    if (kind != WK_PHASE)   up_step = 1'b1;
    else if (cnt == ZERO)   up_step = 1'b1;
    else if (at_top)        up_step = 1'b0;
    else                    up_step = up_reg;
  end

  assign cnt_nxt  = step_count(kind, cnt, top_val, ctc_cmp, up_step);
  assign wrap_evt = en && (kind == WK_FAST) && at_top;
  assign turn_evt = en && (kind == WK_PHASE) && at_top && !up_step;
  assign load_evt = en && is_pwm(kind) && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= ZERO;
      up_reg <= 1'b1;
    end else if (en) begin
      cnt    <= cnt_nxt;
      up_reg <= up_step;
    end
  end
endmodule

// File: rtl/tmr_wave_cmpbuf.sv
module tmr_wave_cmpbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwm,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] eff
);
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              held <= '0;
    else if (!pwm || load)   held <= din;
  end

  assign eff = pwm ? held : din;
endmodule

// File: rtl/tmr_wave_chan.sv
module tmr_wave_chan
  import tmr_wave_pkg::*;
#(
  parameter int W    = 8,
  parameter bit IS_A = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  wave_kind_t   kind,
  input  logic         wm2,
  input  logic [1:0]   cm,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_eff,
  input  logic [W-1:0] top_val,
  input  logic         up_step,
  input  logic         wrap_evt,
  input  logic         turn_evt,
  input  logic         ddr,
  output logic         wave,
  output logic         ovr,
  output logic         pin
);
  logic     hit;
  logic     special;
  pin_act_t act;

  assign hit     = en && (cnt == cmp_eff);
  assign special = is_pwm(kind) && cm[1] && (cmp_eff == top_val);

  always_comb begin
    if (wrap_evt && cm[1])        act = boundary_action(cm);
    else if (turn_evt && special) act = boundary_action(cm);
    else if (hit && !special)     act = match_action(kind, cm, IS_A, wm2, up_step);
    else                          act = ACT_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave <= 1'b0;
    else        wave <= apply_action(act, wave);
  end

  assign ovr = chan_connected(kind, cm, IS_A, wm2);
  assign pin = ovr && ddr && wave;
endmodule

// File: rtl/tmr_wave_unit.sv
module tmr_wave_unit
  import tmr_wave_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [2:0]       wmode,
  input  logic [1:0]       cmode_a,
  input  logic [1:0]       cmode_b,
  input  logic [CNT_W-1:0] cmp_a_in,
  input  logic [CNT_W-1:0] cmp_b_in,
  input  logic             dir_a,
  input  logic             dir_b,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pin_a,
  output logic             pin_b,
  output logic             ovr_a,
  output logic             ovr_b
);
  localparam int NCH = 2;
  localparam logic [CNT_W-1:0] FULL = '1;

  wave_kind_t       kind;
  logic             pwm;
  logic [CNT_W-1:0] top_val;
  logic             up_step, at_top, wrap_evt, turn_evt, load_evt;
  logic             wave_a, wave_b;

  logic [CNT_W-1:0] cmp_in  [NCH];
  logic [CNT_W-1:0] cmp_eff [NCH];
  logic [1:0]       cm_v    [NCH];
  logic             ddr_v   [NCH];
  logic             wave_v  [NCH];
  logic             ovr_v   [NCH];
  logic             pin_v   [NCH];

  assign kind    = decode_kind(wmode);
  assign pwm     = is_pwm(kind);
  assign top_val = top_from_a(wmode) ? cmp_eff[0] : FULL;

  assign cmp_in[0] = cmp_a_in;
  assign cmp_in[1] = cmp_b_in;
  assign cm_v[0]   = cmode_a;
  assign cm_v[1]   = cmode_b;
  assign ddr_v[0]  = dir_a;
  assign ddr_v[1]  = dir_b;

  tmr_wave_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cnt_en),
    .kind     (kind),
    .top_val  (top_val),
    .ctc_cmp  (cmp_a_in),
    .cnt      (cnt_q),
    .up_step  (up_step),
    .at_top   (at_top),
    .wrap_evt (wrap_evt),
    .turn_evt (turn_evt),
    .load_evt (load_evt)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    tmr_wave_cmpbuf #(.W(CNT_W)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .pwm   (pwm),
      .load  (load_evt),
      .din   (cmp_in[ch]),
      .eff   (cmp_eff[ch])
    );

    tmr_wave_chan #(.W(CNT_W), .IS_A(ch == 0)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cnt_en),
      .kind     (kind),
      .wm2      (wmode[2]),
      .cm       (cm_v[ch]),
      .cnt      (cnt_q),
      .cmp_eff  (cmp_eff[ch]),
      .top_val  (top_val),
      .up_step  (up_step),
      .wrap_evt (wrap_evt),
      .turn_evt (turn_evt),
      .ddr      (ddr_v[ch]),
      .wave     (wave_v[ch]),
      .ovr      (ovr_v[ch]),
      .pin      (pin_v[ch])
    );
  end

  assign wave_a = wave_v[0];
  assign wave_b = wave_v[1];
  assign pin_a  = pin_v[0];
  assign pin_b  = pin_v[1];
  assign ovr_a  = ovr_v[0];
  assign ovr_b  = ovr_v[1];
endmodule

// File: rtl/tmr_wave_chk.sv
module tmr_wave_chk
  import tmr_wave_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic [2:0]   wmode,
  input logic [1:0]   cmode_b,
  input logic [W-1:0] cmp_a_in,
  input logic         dir_a,
  input logic         dir_b,
  input logic [W-1:0] cnt_q,
  input logic         pin_a,
  input logic         pin_b,
  input logic         ovr_a,
  input logic         ovr_b,
  input wave_kind_t   kind,
  input logic [W-1:0] top_val,
  input logic         wave_a,
  input logic         wave_b
);
  assert_pin_gated_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pin_a |-> (ovr_a && dir_a));
  assert_pin_gated_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pin_b |-> (ovr_b && dir_b));
  assert_ctc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && wmode == 3'd2 && cnt_q == cmp_a_in) |=> (cnt_q == '0));
  assert_fast_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && kind == WK_FAST && cnt_q >= top_val) |=> (cnt_q == '0));
  assert_phase_bounce_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && kind == WK_PHASE && cnt_q == '0 && top_val != '0) |=> (cnt_q == W'(1)));
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> ($stable(cnt_q) && $stable(wave_a) && $stable(wave_b)));
  assert_resv_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == WK_FAST || kind == WK_PHASE) && cmode_b == 2'b01) |-> !ovr_b);
endmodule

bind tmr_wave_unit tmr_wave_chk #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en   (cnt_en),
  .wmode    (wmode),
  .cmode_b  (cmode_b),
  .cmp_a_in (cmp_a_in),
  .dir_a    (dir_a),
  .dir_b    (dir_b),
  .cnt_q    (cnt_q),
  .pin_a    (pin_a),
  .pin_b    (pin_b),
  .ovr_a    (ovr_a),
  .ovr_b    (ovr_b),
  .kind     (kind),
  .top_val  (top_val),
  .wave_a   (wave_a),
  .wave_b   (wave_b)
);

// File: tb/sim_tmr_wave_unit.sv
module sim_tmr_wave_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b1;
  logic [2:0] wmode = 3'd0;
  logic [1:0] cmode_a = 2'd0, cmode_b = 2'd0;
  logic [7:0] cmp_a_in = 8'd0, cmp_b_in = 8'd0;
  logic       dir_a = 1'b1, dir_b = 1'b1;
  logic [7:0] cnt_q;
  logic       pin_a, pin_b, ovr_a, ovr_b;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] cnt;
    logic       pa, pb, oa, ob;
    string      tag;
  } exp_t;
  exp_t q[$];

  int m_cnt = 0, m_ba = 0, m_bb = 0;
  bit m_up = 1, m_wa = 0, m_wb = 0;

  tmr_wave_unit u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wmode(wmode),
    .cmode_a(cmode_a), .cmode_b(cmode_b), .cmp_a_in(cmp_a_in), .cmp_b_in(cmp_b_in),
    .dir_a(dir_a), .dir_b(dir_b), .cnt_q(cnt_q), .pin_a(pin_a), .pin_b(pin_b),
    .ovr_a(ovr_a), .ovr_b(ovr_b)
  );

  always #5 clk = ~clk;

  // 0 free, 1 clear-on-match, 2 single slope, 3 dual slope
  function automatic int kind_of(logic [2:0] wm);
    if (wm == 3'd1 || wm == 3'd5) return 3;
    if (wm == 3'd3 || wm == 3'd7) return 2;
    if (wm == 3'd2) return 1;
    return 0;
  endfunction

  function automatic bit owns(bit is_a, int cm, int k, bit wm2);
    if (cm == 0) return 0;
    if (k >= 2 && cm == 1) return is_a && wm2;
    return 1;
  endfunction

  function automatic bit next_wave(bit is_a, bit cur, int cm, int e, int topv, int k,
                                   bit wm2, int c, bit up);
    bit pwm_m = (k >= 2);
    bit spec  = pwm_m && cm >= 2 && e == topv;
    if (k == 2 && cm >= 2 && c >= topv) return (cm == 2);
    if (k == 3 && spec && c >= topv && !up) return (cm == 2);
    if (c != e || spec || cm == 0) return cur;
    if (!pwm_m) return (cm == 1) ? !cur : (cm == 3);
    if (cm == 1) return (is_a && wm2) ? !cur : cur;
    if (k == 2) return (cm == 3);
    return (cm == 2) ? !up : up;
  endfunction

  task automatic tick(string tag);
    exp_t e;
    int k, topv, ea, eb, nc;
    bit up, oa, ob;
    k    = kind_of(wmode);
    oa   = owns(1, int'(cmode_a), k, wmode[2]);
    ob   = owns(0, int'(cmode_b), k, wmode[2]);
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_wa = 0; m_wb = 0; m_ba = 0; m_bb = 0;
    end else begin
      topv = (k >= 2 && wmode[2]) ? m_ba : 255;
      ea   = (k >= 2) ? m_ba : int'(cmp_a_in);
      eb   = (k >= 2) ? m_bb : int'(cmp_b_in);
      up   = (k != 3) ? 1'b1 : (m_cnt == 0) ? 1'b1 : (m_cnt >= topv) ? 1'b0 : m_up;
      if (cnt_en) begin
        m_wa = next_wave(1, m_wa, int'(cmode_a), ea, topv, k, wmode[2], m_cnt, up);
        m_wb = next_wave(0, m_wb, int'(cmode_b), eb, topv, k, wmode[2], m_cnt, up);
        case (k)
          1: nc = (m_cnt == int'(cmp_a_in)) ? 0 : (m_cnt + 1) % 256;
          2: nc = (m_cnt >= topv) ? 0 : m_cnt + 1;
          3: nc = (topv == 0) ? 0 : (up ? m_cnt + 1 : m_cnt - 1);
          default: nc = (m_cnt + 1) % 256;
        endcase
        if (k >= 2 && m_cnt >= topv) begin
          m_ba = int'(cmp_a_in); m_bb = int'(cmp_b_in);
        end
        m_cnt = nc;
        m_up  = up;
      end
      if (k < 2) begin
        m_ba = int'(cmp_a_in); m_bb = int'(cmp_b_in);
      end
    end
    e.cnt = 8'(m_cnt);
    e.pa  = oa && dir_a && m_wa;
    e.pb  = ob && dir_b && m_wb;
    e.oa  = oa;
    e.ob  = ob;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic restart(logic [2:0] wm, logic [1:0] ca, logic [1:0] cb,
                         logic [7:0] va, logic [7:0] vb);
    rst_n = 1'b0;
    wmode = wm; cmode_a = ca; cmode_b = cb; cmp_a_in = va; cmp_b_in = vb;
    dir_a = 1'b1; dir_b = 1'b1; cnt_en = 1'b1;
    run(2, "R1 reset");
    rst_n = 1'b1;
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (cnt_q !== e.cnt || pin_a !== e.pa || pin_b !== e.pb ||
            ovr_a !== e.oa || ovr_b !== e.ob) begin
          n_fail++;
          $display("FAIL %s: cnt/pa/pb/oa/ob got %h/%b/%b/%b/%b expected %h/%b/%b/%b/%b",
                   e.tag, cnt_q, pin_a, pin_b, ovr_a, ovr_b,
                   e.cnt, e.pa, e.pb, e.oa, e.ob);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    restart(3'd0, 2'b00, 2'b00, 8'd0, 8'd0);
    // free counting: A toggles at 10, B sets at 20 (R2 R3)
    restart(3'd0, 2'b01, 2'b11, 8'd10, 8'd20);
    run(300, "R3 free toggle/set");
    cmode_b = 2'b10;
    run(300, "R3 free clear");
    dir_a = 1'b0;
    run(80, "R4 drive disallowed");
    cmode_a = 2'b00;
    run(40, "R4 field off");
    // clear on match at 50 (R5)
    restart(3'd2, 2'b01, 2'b01, 8'd50, 8'd30);
    run(300, "R5 clear on match");
    // single slope, TOP 255 (R6 R9)
    restart(3'd3, 2'b10, 2'b11, 8'd100, 8'd60);
    run(600, "R6 single slope");
    // compare at TOP and reserved B field (R7 R8)
    restart(3'd3, 2'b10, 2'b01, 8'd255, 8'd40);
    run(600, "R7 R8 single slope top");
    cmode_a = 2'b11;
    run(600, "R7 single slope top inverted");
    // TOP from A, A toggles, B buffered write mid period (R8 R9 R10)
    restart(3'd7, 2'b01, 2'b10, 8'd120, 8'd40);
    run(300, "R9 top from A");
    cmp_b_in = 8'd80; cmp_a_in = 8'd150;
    run(500, "R10 buffered write");
    // dual slope TOP 255 (R11)
    restart(3'd1, 2'b10, 2'b11, 8'd100, 8'd200);
    run(1100, "R11 dual slope");
    cmp_a_in = 8'd255; cmp_b_in = 8'd255;
    run(1100, "R7 dual slope top");
    cmode_a = 2'b01;
    run(300, "R8 A field 01 with wmode[2]=0");
    // dual slope TOP from A, buffered B change (R10 R11)
    restart(3'd5, 2'b01, 2'b10, 8'd90, 8'd30);
    run(400, "R11 dual slope top A");
    cmp_b_in = 8'd60;
    run(400, "R10 dual slope buffered");
    // irregular enable (R12)
    restart(3'd3, 2'b10, 2'b11, 8'd70, 8'd150);
    for (int i = 0; i < 900; i++) begin
      cnt_en = (i % 3 != 0) && (i % 7 != 2);
      tick("R12 enable gating");
    end
    cnt_en = 1'b1;
    restart(3'd0, 2'b01, 2'b00, 8'd5, 8'd0);
    for (int i = 0; i < 300; i++) begin
      cnt_en = (i % 5 == 1);
      tick("R12 enable gating free");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule